// File: doc/BRIEF.md
# Nine-bit serial frame transmitter

This block sends one asynchronous frame per host write: a low start bit, eight data bits with the least significant bit first, a ninth bit chosen by the host, and a high stop bit. That makes eleven bit times. Bit boundaries come from a shared prescaler that pulses `bit_tick` once per bit time (its divide-by-16 rollover). The frame always starts on a bit boundary, never on the write itself.

The host writes a byte together with its ninth bit through a single strobe. The block raises `busy` at once, waits for the next tick, and then shifts the frame out on `txd`. No bit counter is used. The first shift of the frame pushes a one marker into the top of the nine-bit shift register, and every later shift pushes in zeros. The frame is finished when the register holds only the ninth bit, with the marker beside it and zeros above it. At that point the block makes one last shift, drops `busy` and sets a sticky done flag that the host clears.

Top module: `ninebit_frame_tx`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0 and `done_flag` is 0. While `busy` is 0, `txd` is 1.
- R2: A `wr_stb` pulse while `busy` is 0 captures `wr_data` and `wr_ninth`, and `busy` is 1 from the next cycle. A `wr_stb` while `busy` is 1 is ignored: the frame in flight and `busy` are unchanged.
- R3: The frame starts at the first `bit_tick` after the write cycle. A tick in the write cycle itself does not count. Until that tick `txd` stays 1. For the bit time after it, `txd` is 0 (the start bit).
- R4: After the 2nd tick `txd` carries `wr_data[0]`. Each later tick moves on by one bit, through `wr_data[7]` after the 9th tick, and `wr_ninth` after the 10th tick.
- R5: The first shift of a frame puts a 1 marker into the top register position. The end of the frame is found only from the marker pattern. A data pattern that looks like the end pattern before the first shift (for example byte 0x02 with ninth bit 0) still sends every bit.
- R6: At the 11th tick after the write, `busy` falls, `done_flag` rises and `txd` returns to 1 as the stop bit. The stop bit lasts at least one full bit time, because a following frame cannot start before the next tick.
- R7: `done_flag` stays 1 until a `done_clr` pulse. It is 0 in the cycle after that pulse.
- R8: `txd` changes only in the cycle right after a `bit_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_tick | input | 1 | One-cycle pulse at each prescaler rollover (one bit time) |
| wr_stb | input | 1 | Host write strobe |
| wr_data | input | 8 | Data byte to send |
| wr_ninth | input | 1 | Value of the ninth frame bit |
| done_clr | input | 1 | Host clear pulse for the done flag |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame pending or being sent |
| done_flag | output | 1 | Sticky end-of-frame flag |

## Verification
`busy` is due in the cycle after the write strobe. The `txd` value of bit k, and the final rise of `done_flag` with the fall of `busy`, are due in the cycle after the k-th tick that follows the write cycle. The monitor therefore counts ticks seen at rising edges, starting from the edge after the write, and samples each result at the falling edge that comes after that tick. The done-flag clear is checked at the falling edge one cycle after the clear pulse. A write made while a frame is in flight must leave the observed bit sequence unchanged.

// File: rtl/nbtx_pkg.sv
package nbtx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SEND,
    ST_FIRST,
    ST_DATA
  } tx_state_e;
endpackage

// File: rtl/nbtx_shifter.sv
module nbtx_shifter #(
  parameter int SR_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [SR_W-1:0] load_val,
  input  logic            shift,
  input  logic            fill_bit,
  output logic [SR_W-1:0] q,
  output logic            drained
);
  // The frame is drained when only the ninth bit is left, the marker sits just above it, and all higher positions are zero.
  function automatic logic is_drained(input logic [SR_W-1:0] v);
    return (v[SR_W-1:2] == '0) && v[1];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (load) q <= load_val;
    else if (shift) q <= {fill_bit, q[SR_W-1:1]};
  end

  assign drained = is_drained(q);

  // R5: a marker fill lands in the top position
  a_r5_marker_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load && fill_bit) |=> q[SR_W-1]);
endmodule

// File: rtl/nbtx_done_flag.sv
module nbtx_done_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R7: sticky until cleared
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);
endmodule

// File: rtl/ninebit_frame_tx.sv
module ninebit_frame_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_ninth,
  input  logic              done_clr,
  output logic              txd,
  output logic              busy,
  output logic              done_flag
);
  import nbtx_pkg::*;

  localparam int SR_W       = DATA_W + 1;
  localparam int FRAME_BITS = DATA_W + 3;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  tx_state_e        state_q, state_d;
  logic [SR_W-1:0]  sr_q;
  logic             sr_drained;
  logic             wr_take;
  logic             do_shift;
  logic             fill_bit;
  logic             frame_end;
  logic [CNT_W-1:0] tick_cnt_q;

  assign wr_take = wr_stb && (state_q == ST_IDLE);

  always_comb begin
    state_d   = state_q;
    do_shift  = 1'b0;
    fill_bit  = 1'b0;
    frame_end = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (wr_take) state_d = ST_WAIT;
      ST_WAIT:  if (bit_tick) state_d = ST_SEND;
      ST_SEND:  if (bit_tick) state_d = ST_FIRST;
      ST_FIRST: if (bit_tick) begin
        state_d  = ST_DATA;
        do_shift = 1'b1;
        fill_bit = 1'b1;
      end
      ST_DATA:  if (bit_tick) begin
        do_shift = 1'b1;
        if (sr_drained) begin
          state_d   = ST_IDLE;
          frame_end = 1'b1;
        end
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else state_q <= state_d;
  end

  // Tick count since the write, kept so the assertions can check the frame length.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_cnt_q <= '0;
    else if (wr_take) tick_cnt_q <= '0;
    else if (bit_tick && state_q != ST_IDLE) tick_cnt_q <= tick_cnt_q + 1'b1;
  end

  nbtx_shifter #(.SR_W(SR_W)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_take),
    .load_val ({wr_ninth, wr_data}),
    .shift    (do_shift),
    .fill_bit (fill_bit),
    .q        (sr_q),
    .drained  (sr_drained)
  );

  nbtx_done_flag u_done (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (frame_end),
    .clr   (done_clr),
    .flag  (done_flag)
  );

  always_comb begin
    unique case (state_q)
      ST_SEND:           txd = 1'b0;
      ST_FIRST, ST_DATA: txd = sr_q[0];
      default:           txd = 1'b1;
    endcase
  end

  assign busy = (state_q != ST_IDLE);

  // R1: idle line is high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  // R2: a write during a frame leaves the shift register untouched
  a_r2_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_stb && !bit_tick) |=> $stable(sr_q));
  // R6: completion lands on the 11th tick after the write
  a_r6_eleventh_tick: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (tick_cnt_q == CNT_W'(FRAME_BITS - 1)));
  // R6: busy only drops together with a set done flag
  a_r6_busy_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_flag);
  // R8: line changes only after a tick
  a_r8_tick_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(bit_tick));
endmodule

// File: tb/test_ninebit_frame_tx.sv
module test_ninebit_frame_tx;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_ninth = 1'b0;
  logic       done_clr = 1'b0;
  logic       txd, busy, done_flag;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;
  bit  mon_busy = 0;
  bit  exp_q[$];
  event go;

  ninebit_frame_tx i_ninebit_frame_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_stb(wr_stb),
    .wr_data(wr_data), .wr_ninth(wr_ninth), .done_clr(done_clr),
    .txd(txd), .busy(busy), .done_flag(done_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      repeat (TICK_DIV - 1) @(negedge clk);
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Driver: pushes the expected line values, then pulses the write.
  task automatic send_frame(input logic [7:0] d, input logic b9);
    @(negedge clk);
    exp_q.push_back(1'b0);
    for (int i = 0; i < 8; i++) exp_q.push_back(d[i]);
    exp_q.push_back(b9);
    wr_data = d; wr_ninth = b9; wr_stb = 1'b1;
    mon_busy = 1;
    @(posedge clk);
    #1 wr_stb = 1'b0;
    ->go;
    @(negedge clk);
    check("R2 busy after write", busy, 1'b1);
    check("R3 line high before start", txd, 1'b1);
  endtask

  task automatic poke(input logic [7:0] d, input logic b9);
    @(negedge clk);
    wr_data = d; wr_ninth = b9; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic clear_done();
    @(negedge clk);
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    check("R7 cleared after pulse", done_flag, 1'b0);
  endtask

  // Monitor: counts ticks after the write and compares each bit.
  initial begin
    forever begin
      @(go);
      for (int k = 1; k <= 11; k++) begin
        do @(posedge clk); while (!bit_tick);
        @(negedge clk);
        if (k <= 10) begin
          check(k == 1 ? "R3 start bit" : "R4 data bit", txd, exp_q.pop_front());
          check("R2 busy mid-frame", busy, 1'b1);
          check("R6 no early done", done_flag, 1'b0);
        end else begin
          check("R6 busy falls", busy, 1'b0);
          check("R6 done set", done_flag, 1'b1);
          check("R6 stop bit high", txd, 1'b1);
        end
      end
      mon_busy = 0;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 txd after reset", txd, 1'b1);
    check("R1 busy after reset", busy, 1'b0);
    check("R1 done after reset", done_flag, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    send_frame(8'hA5, 1'b0); wait (!mon_busy);
    repeat (20) @(negedge clk);
    check("R7 flag sticky", done_flag, 1'b1);
    check("R1 idle high", txd, 1'b1);
    clear_done();

    send_frame(8'h00, 1'b1); wait (!mon_busy); clear_done();
    send_frame(8'hFF, 1'b0); wait (!mon_busy); clear_done();
    // R5: the byte looks like the end pattern before the first shift
    send_frame(8'h02, 1'b0); wait (!mon_busy); clear_done();

    // R2: a write during the frame is ignored
    send_frame(8'h5A, 1'b1);
    repeat (12) @(negedge clk);
    poke(8'hC3, 1'b0);
    wait (!mon_busy);
    @(negedge clk);
    check("R2 ignored write no new frame", busy, 1'b0);
    clear_done();

    // Back-to-back frames: R6 stop bit before the next start
    send_frame(8'h81, 1'b1); wait (!mon_busy); clear_done();
    send_frame(8'h3C, 1'b0); wait (!mon_busy);
    repeat (30) @(negedge clk);
    check("R8 idle line steady", txd, 1'b1);
    clear_done();

    finish_run();
  end
endmodule